// File: doc/BRIEF.md
# Rounded Output Window Selector with Cascade Adder

This block sits at the output of a multiply-accumulate array that produces a 36-bit two's complement sum for each accepted input sample. It takes a 24-bit window out of that sum and rounds it half-up. Any window bits that lie above bit 35 are filled by sign extension. The block then adds a 24-bit cascade word to the rounded window and registers the 24-bit result. The cascade word is the one that arrived 32 accepted samples earlier, held in an internal delay line.

Two kinds of numeric trouble are reported. A selector overflow means the chosen window cannot represent the rounded result. An adder overflow means the 24-bit cascade addition left the signed range. Each kind has a status latch that software arms and clears through a small write interface. An active-low error output summarises both latches. It is meant to be combined off-chip with the same output of neighbouring blocks, where any device pulling low signals an error.

Top module: `acc_window_out`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_valid` goes low, `res_data` goes to zero, both status latches clear and disarm, every delay-line entry becomes zero, `error_n` goes high, the window code becomes 2'b10 and the test override turns off.
- R2: The window code picks the least significant result bit as follows: 2'b00 picks bit 7, 2'b01 picks bit 11, 2'b10 picks bit 15 and 2'b11 picks bit 20. The window is the 24 bits upward from that bit, and positions above bit 35 repeat bit 35. A write (`win_we`) takes effect for samples accepted after the write edge.
- R3: With the test override on (`full_we` writes `full_on`), the window is `acc_sum[22:0]` followed by a zero bit, and the window code is ignored.
- R4: Rounding adds the bit just below the window's least significant bit (none under the override). So an exact half rounds toward positive infinity: +1.5 gives 2 and -1.5 gives -1.
- R5: A selector overflow occurs when the rounded value lies outside -2^23 to 2^23-1. This includes a carry out of rounding. The window output then keeps its low 24 bits.
- R6: The cascade term added to sample k is the `casc_in` value accepted with sample k-32. Clock cycles without `acc_valid` do not move the delay line.
- R7: An adder overflow occurs when the signed 24-bit sum of the window and the cascade term leaves the 24-bit range. `res_data` then holds the wrapped sum, not a saturated value.
- R8: `res_valid` is high for exactly the cycle after each cycle with `acc_valid` high. `res_data` changes only at those edges.
- R9: Status index 0 is the selector latch and index 1 is the adder latch. Writing 1 through `err_wr_en`/`err_wr_data` arms a latch. An overflow on an accepted sample sets the latch only if the latch is armed. Writing 0 clears the latch and disarms it. A write takes priority over an event in the same cycle.
- R10: A write of 0 to the adder latch leaves the flag set if the most recently registered result overflowed the adder. It still disarms the latch.
- R11: `error_n` is low exactly while `sel_err` or `add_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Accepted sample: `acc_sum` and `casc_in` are valid |
| acc_sum | input | 36 | Full-precision signed sum from the MAC array |
| casc_in | input | 24 | Cascade word from the upstream block |
| win_we | input | 1 | Write strobe for the window code |
| win_code | input | 2 | Window code to store |
| full_we | input | 1 | Write strobe for the test override |
| full_on | input | 1 | Test override value to store |
| err_wr_en | input | 2 | Per-latch write strobe (0 selector, 1 adder) |
| err_wr_data | input | 2 | Per-latch write value: 1 arms, 0 clears |
| res_valid | output | 1 | Result registered this cycle |
| res_data | output | 24 | Rounded window plus delayed cascade word |
| sel_err | output | 1 | Selector overflow latch |
| add_err | output | 1 | Adder overflow latch |
| error_n | output | 1 | Active-low error summary |

## Verification
The bench goes after rounding at exact halves on both signs, where a design that truncates or rounds away from zero gets -1.5 wrong. It drives a rounding carry that pushes a just-fitting value out of range; a design that tests for overflow before rounding would miss it. It spaces samples apart with idle cycles across more than 32 samples, so a delay line that advances every clock, or has the wrong depth, adds the wrong cascade term. It also tries to clear the adder latch while the last result still overflows, and it lets overflows occur on disarmed latches. Either mistake would leave `error_n` in the wrong state.

// File: rtl/ofs_pkg.sv
// Package: shared widths, window positions and latch indices for the
// rounded output window selector. Window LSB positions are behaviour
// (they define the numeric scale of the result), so they live here.
package ofs_pkg;

    localparam int ACC_W      = 36;   // width of the MAC array sum
    localparam int OUT_W      = 24;   // width of window, cascade word, result
    localparam int CASC_DEPTH = 32;   // cascade delay in accepted samples
    localparam int NUM_ERR    = 2;    // number of status latches

    // least significant bit of the window for each code
    localparam int LSB_C0 = 7;
    localparam int LSB_C1 = 11;
    localparam int LSB_C2 = 15;
    localparam int LSB_C3 = 20;

    typedef enum logic [1:0] {
        WIN_C0 = 2'b00,
        WIN_C1 = 2'b01,
        WIN_C2 = 2'b10,
        WIN_C3 = 2'b11
    } win_code_e;

    localparam win_code_e WIN_RESET = WIN_C2;

    // status latch indices
    localparam int ERR_SEL = 0;
    localparam int ERR_ADD = 1;

endpackage

// File: rtl/ofs_window.sv
// ofs_window: combinational window pick, half-up rounding and selector
// overflow test. Assumes a two's complement acc_i. The value is shifted
// in a width two bits wider than the input, so neither the override
// left shift nor the rounding carry can lose information before the
// range test.
module ofs_window
    import ofs_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int OW = OUT_W
) (
    input  logic [AW-1:0] acc_i,
    input  win_code_e     code_i,
    input  logic          full_i,
    output logic [OW-1:0] field_o,
    output logic          ovf_o
);

    localparam int VW = AW + 2;       // working width
    localparam int HW = VW - OW + 1;  // bits that must agree for a fit

    logic signed [VW-1:0] acc_x;
    logic signed [VW-1:0] shifted;
    logic signed [VW-1:0] rounded;
    logic                 rbit;
    logic [HW-1:0]        hi_bits;

    // sign-extend the sum into the working width
    assign acc_x = {{(VW-AW){acc_i[AW-1]}}, acc_i};

    // align the chosen window to bit 0 and find its rounding bit
    always_comb begin
        shifted = '0;
        rbit    = 1'b0;
        if (full_i) begin
            shifted = acc_x <<< 1;
            rbit    = 1'b0;
        end else begin
            unique case (code_i)
                WIN_C0: begin shifted = acc_x >>> LSB_C0; rbit = acc_x[LSB_C0-1]; end
                WIN_C1: begin shifted = acc_x >>> LSB_C1; rbit = acc_x[LSB_C1-1]; end
                WIN_C2: begin shifted = acc_x >>> LSB_C2; rbit = acc_x[LSB_C2-1]; end
                WIN_C3: begin shifted = acc_x >>> LSB_C3; rbit = acc_x[LSB_C3-1]; end
                default: begin shifted = '0; rbit = 1'b0; end
            endcase
        end
    end

    // half-up rounding: add the bit below the window
    assign rounded = shifted + {{(VW-1){1'b0}}, rbit};

    // fits only when every bit from the field sign upward agrees
    assign hi_bits = rounded[VW-1:OW-1];
    assign ovf_o   = !((&hi_bits) || !(|hi_bits));
    assign field_o = rounded[OW-1:0];

endmodule

// File: rtl/ofs_delay.sv
// ofs_delay: cascade delay line of DEPTH entries, WIDTH bits each.
// Advances by one entry only when adv_i is high (one accepted sample).
// tail_o is the word accepted DEPTH advances ago. Entries are cleared
// by reset, so early results carry a zero cascade term.
module ofs_delay #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] tail_o
);

    logic [WIDTH-1:0] stage_q [DEPTH];

    // first entry takes the incoming word on each advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else if (adv_i) begin
            stage_q[0] <= din_i;
        end
    end

    // remaining entries shift from their neighbour on each advance
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (adv_i) begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign tail_o = stage_q[DEPTH-1];

endmodule

// File: rtl/ofs_err_latch.sv
// ofs_err_latch: one armable status latch. Writing 1 arms it; writing 0
// disarms it and clears the flag unless clr_block_i is high. An event
// sets the flag only while armed. A write wins over a same-cycle event.
module ofs_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic wr_en_i,
    input  logic wr_data_i,
    input  logic clr_block_i,
    output logic flag_o
);

    logic armed_q;
    logic flag_q;

    // arm, clear and capture state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            flag_q  <= 1'b0;
        end else if (wr_en_i) begin
            armed_q <= wr_data_i;
            if (!wr_data_i && !clr_block_i) begin
                flag_q <= 1'b0;
            end
        end else if (event_i && armed_q) begin
            flag_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/acc_window_out.sv
// acc_window_out: picks a rounded 24-bit window from the MAC sum, adds
// the cascade word delayed by CASC_DEPTH accepted samples, registers
// the result and keeps two armable overflow latches plus an active-low
// summary. Assumes configuration changes only between samples.
module acc_window_out
    import ofs_pkg::*;
#(
    parameter int AW    = ACC_W,
    parameter int OW    = OUT_W,
    parameter int DEPTH = CASC_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_sum,
    input  logic [OW-1:0] casc_in,
    input  logic          win_we,
    input  logic [1:0]    win_code,
    input  logic          full_we,
    input  logic          full_on,
    input  logic [1:0]    err_wr_en,
    input  logic [1:0]    err_wr_data,
    output logic          res_valid,
    output logic [OW-1:0] res_data,
    output logic          sel_err,
    output logic          add_err,
    output logic          error_n
);

    win_code_e        code_q;
    logic             full_q;
    logic [OW-1:0]    field;
    logic             sel_ovf;
    logic [OW-1:0]    tail;
    logic [OW-1:0]    sum;
    logic             add_ovf;
    logic             add_cond_q;
    logic             valid_q;
    logic [OW-1:0]    res_q;
    logic [NUM_ERR-1:0] err_event;
    logic [NUM_ERR-1:0] err_block;
    logic [NUM_ERR-1:0] err_flag;

    // window configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= WIN_RESET;
            full_q <= 1'b0;
        end else begin
            if (win_we)  code_q <= win_code_e'(win_code);
            if (full_we) full_q <= full_on;
        end
    end

    ofs_window #(.AW(AW), .OW(OW)) u_window (
        .acc_i   (acc_sum),
        .code_i  (code_q),
        .full_i  (full_q),
        .field_o (field),
        .ovf_o   (sel_ovf)
    );

    ofs_delay #(.WIDTH(OW), .DEPTH(DEPTH)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (acc_valid),
        .din_i  (casc_in),
        .tail_o (tail)
    );

    // wrapping cascade addition with signed overflow test
    assign sum     = field + tail;
    assign add_ovf = (field[OW-1] == tail[OW-1]) && (sum[OW-1] != field[OW-1]);

    // result register and last-result adder condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            res_q      <= '0;
            add_cond_q <= 1'b0;
        end else begin
            valid_q <= acc_valid;
            if (acc_valid) begin
                res_q      <= sum;
                add_cond_q <= add_ovf;
            end
        end
    end

    assign err_event[ERR_SEL] = acc_valid && sel_ovf;
    assign err_event[ERR_ADD] = acc_valid && add_ovf;
    assign err_block[ERR_SEL] = 1'b0;
    assign err_block[ERR_ADD] = add_cond_q;

    for (genvar e = 0; e < NUM_ERR; e++) begin : g_err
        ofs_err_latch u_latch (
            .clk         (clk),
            .rst_n       (rst_n),
            .event_i     (err_event[e]),
            .wr_en_i     (err_wr_en[e]),
            .wr_data_i   (err_wr_data[e]),
            .clr_block_i (err_block[e]),
            .flag_o      (err_flag[e])
        );
    end

    assign res_valid = valid_q;
    assign res_data  = res_q;
    assign sel_err   = err_flag[ERR_SEL];
    assign add_err   = err_flag[ERR_ADD];
    assign error_n   = !(|err_flag);

endmodule

// File: rtl/ofs_checker.sv
// ofs_checker: temporal properties over the ports of acc_window_out.
module ofs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [1:0] err_wr_en,
    input logic [1:0] err_wr_data,
    input logic       res_valid,
    input logic [23:0] res_data,
    input logic       sel_err,
    input logic       add_err,
    input logic       error_n
);

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(res_data)); // R8
    AST_SEL_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_err) |-> $past(acc_valid)); // R9
    AST_ADD_SET_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(add_err) |-> $past(acc_valid)); // R9
    AST_SEL_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_err) |-> $past(err_wr_en[0] && !err_wr_data[0])); // R9
    AST_ADD_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(add_err) |-> $past(err_wr_en[1] && !err_wr_data[1])); // R10
    AST_ERROR_PIN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(error_n) |-> $past(acc_valid)); // R11

endmodule

bind acc_window_out ofs_checker u_ofs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .err_wr_en   (err_wr_en),
    .err_wr_data (err_wr_data),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .sel_err     (sel_err),
    .add_err     (add_err),
    .error_n     (error_n)
);

// File: tb/test_acc_window_out.sv
// Scoreboard bench: send() computes the expected result from the
// requirements and queues it; the monitor pops and compares at negedge.
`timescale 1ns/100ps
module test_acc_window_out;

    typedef struct {
        logic [23:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [35:0] acc_sum = '0;
    logic [23:0] casc_in = '0;
    logic        win_we = 1'b0;
    logic [1:0]  win_code = 2'b00;
    logic        full_we = 1'b0;
    logic        full_on = 1'b0;
    logic [1:0]  err_wr_en = 2'b00;
    logic [1:0]  err_wr_data = 2'b00;
    logic        res_valid;
    logic [23:0] res_data;
    logic        sel_err;
    logic        add_err;
    logic        error_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    exp_t        sb_q[$];
    logic [23:0] hist[32];
    logic [1:0]  cur_code = 2'b10;
    bit          cur_full = 1'b0;
    bit          last_sovf;
    bit          last_aovf;

    always #2.5 clk = ~clk;

    acc_window_out i_acc_window_out (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sum(acc_sum),
        .casc_in(casc_in), .win_we(win_we), .win_code(win_code),
        .full_we(full_we), .full_on(full_on), .err_wr_en(err_wr_en),
        .err_wr_data(err_wr_data), .res_valid(res_valid), .res_data(res_data),
        .sel_err(sel_err), .add_err(add_err), .error_n(error_n)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // model of R2..R7 and stimulus for one accepted sample
    task automatic send(input logic [35:0] acc, input logic [23:0] casc, input string tag);
        longint a, v, r, s, t;
        int lsb;
        logic [23:0] sel24, tl, res;
        exp_t e;
        a = longint'($signed(acc));
        if (cur_full) begin
            v = a * 2; r = 0;
        end else begin
            case (cur_code)
                2'b00: lsb = 7;
                2'b01: lsb = 11;
                2'b10: lsb = 15;
                default: lsb = 20;
            endcase
            v = a >>> lsb;
            r = (a >>> (lsb - 1)) & 1;
        end
        s = v + r;
        last_sovf = (s > 64'sd8388607) || (s < -64'sd8388608);
        sel24 = s[23:0];
        tl = hist[31];
        for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = casc;
        t = longint'($signed(sel24)) + longint'($signed(tl));
        last_aovf = (t > 64'sd8388607) || (t < -64'sd8388608);
        res = t[23:0];
        e.data = res; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        acc_sum = acc; casc_in = casc; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic set_win(input logic [1:0] c, input bit f);
        @(negedge clk);
        win_code = c; win_we = 1'b1; full_on = f; full_we = 1'b1;
        @(negedge clk);
        win_we = 1'b0; full_we = 1'b0;
        cur_code = c; cur_full = f;
    endtask

    task automatic err_write(input int idx, input bit val);
        @(negedge clk);
        err_wr_en[idx] = 1'b1; err_wr_data[idx] = val;
        @(negedge clk);
        err_wr_en = 2'b00; err_wr_data = 2'b00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pop and compare each produced result
    always @(negedge clk) begin
        if (rst_n && res_valid && !done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", res_data, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(res_data === e.data, e.tag, res_data, e.data);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) hist[i] = '0;
        idle(3);
        // R1 reset state
        check(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
        check(res_data === 24'h0, "R1 res_data", res_data, 0);
        check(sel_err === 1'b0 && add_err === 1'b0, "R1 flags", {sel_err, add_err}, 0);
        check(error_n === 1'b1, "R1 error_n", error_n, 1);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R1/R2 default code 10 (lsb 15), several patterns
        send(36'h0_1234_5000, 24'h0, "R2 default code");
        send(36'hF_F000_0000, 24'h0, "R2 negative default");
        send(36'h7_FFFF_FFFF, 24'h0, "R2 max positive");
        // R8 result held and valid drops
        @(negedge clk);
        check(res_valid === 1'b0, "R8 valid one cycle", res_valid, 0);

        // R4 rounding at exact halves
        send(36'd3 << 14, 24'h0, "R4 +1.5 rounds to 2");
        send(-(36'd3 << 14), 24'h0, "R4 -1.5 rounds to -1");
        send((36'd1 << 14) - 1, 24'h0, "R4 below half");

        // R2 remaining codes
        set_win(2'b00, 1'b0);
        send(36'h0_0ABC_DE40, 24'h0, "R2 code 00");
        set_win(2'b01, 1'b0);
        send(36'hF_8765_4321, 24'h0, "R2 code 01");
        set_win(2'b11, 1'b0);
        send(36'h8_0000_0000, 24'h0, "R2 code 11 sign extend");
        send(36'h7_FFFF_FFFF, 24'h0, "R2 code 11 max");

        // R3 test override
        set_win(2'b11, 1'b1);
        send(36'h0_0012_3456, 24'h0, "R3 override");
        send(36'hF_FFC0_0001, 24'h0, "R3 override negative");

        // R5/R9/R11 selector latch
        set_win(2'b00, 1'b0);
        send(36'h7_FFFF_FFFF, 24'h0, "R5 overflow wraps");
        check(sel_err === 1'b0, "R9 disarmed ignores overflow", sel_err, 0);
        check(error_n === 1'b1, "R11 no error while clear", error_n, 1);
        err_write(0, 1'b1);
        send(36'h0_3FFF_FFC0, 24'h0, "R5 rounding carry wraps");
        check(last_sovf == 1'b1, "R5 model carry overflow", last_sovf, 1);
        check(sel_err === 1'b1, "R5 rounding carry sets flag", sel_err, 1);
        check(error_n === 1'b0, "R11 error low", error_n, 0);
        err_write(0, 1'b0);
        check(sel_err === 1'b0, "R9 clear", sel_err, 0);
        check(error_n === 1'b1, "R11 error released", error_n, 1);
        send(36'h7_FFFF_FFFF, 24'h0, "R5 overflow after disarm");
        check(sel_err === 1'b0, "R9 clear also disarms", sel_err, 0);

        // R6 delay line with idle gaps
        set_win(2'b10, 1'b0);
        for (int k = 0; k < 40; k++) begin
            send(36'h0_0000_8000 * k, 24'h000100 + k, "R6 cascade delay");
            if (k % 5 == 0) idle(3);
        end

        // R7/R10 adder latch
        set_win(2'b00, 1'b0);
        for (int k = 0; k < 32; k++) send(36'h0, 24'h400000, "R6 load cascade");
        err_write(1, 1'b1);
        send(36'h0_2000_0000, 24'h0, "R7 adder wraps");
        check(last_aovf == 1'b1, "R7 model overflow", last_aovf, 1);
        check(add_err === 1'b1, "R7 adder flag set", add_err, 1);
        check(error_n === 1'b0, "R11 error from adder", error_n, 0);
        err_write(1, 1'b0);
        check(add_err === 1'b1, "R10 clear blocked", add_err, 1);
        send(36'h0, 24'h0, "R7 clean sum");
        err_write(1, 1'b0);
        check(add_err === 1'b0, "R10 clear after clean sum", add_err, 0);
        check(error_n === 1'b1, "R11 error released", error_n, 1);

        idle(4);
        check(sb_q.size() == 0, "R8 all results seen", sb_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule